// File: doc/BRIEF.md
# CPU halt and wake controller

This block puts a small processor core into a halt state and brings it back out. While the core runs, a halt request from the instruction decoder stops the CPU clock enable. The peripheral clock enable stays high the whole time. While halted, the block watches a non-maskable interrupt line, a vector of maskable interrupt requests, and four reset sources: external pin, watchdog, low-voltage and clock monitor.

Waking and acknowledging are two separate decisions.

- **Waking.** Any pending non-maskable request ends the halt. So does any pending maskable request whose enable bit is set, whatever its priority.
- **Acknowledging.** When the halt ends, the block decides whether the waking request is taken:
  - It pulses an acknowledge with the vector index when the request is taken.
  - Otherwise it pulses a "resume at next instruction" indication and leaves the request pending.

The core supplies two inputs for this decision: the priority level it is currently servicing (8 means no handler is active) and its global interrupt enable.

Top module: `halt_wake_ctrl`

## Requirements
- R1: When `halt_req` is high in a cycle in which `cpu_clk_en` is high and no reset source is active, `cpu_clk_en` is low from the next cycle on. `periph_clk_en` is 1 at all times.
- R2: A high level on `irq_req[i]` or `nmi` sets a pending flag at the next clock edge. The flag is cleared only by an acknowledge of that request or by a reset source. A request that is high on the acknowledge edge sets the flag again.
- R3: While halted, a pending `nmi` or a pending `irq_req[i]` with `irq_en[i]=1` makes `cpu_clk_en` go high and `wake` go high at the next edge. `wake` lasts exactly one cycle. A pending request with `irq_en[i]=0` does not end the halt.
- R4: A halt request made while an eligible request is already pending gives exactly one cycle with `cpu_clk_en` low, followed by the wake.
- R5: A wake while a non-maskable request is pending gives `ack=1` and `ack_nmi=1`, whatever the values of `int_en` and `cur_lvl`. The non-maskable request outranks every maskable request.
- R6: On a wake without a pending non-maskable request, the winning maskable request is acknowledged when `int_en=1` and its level is numerically below `cur_lvl`. The result is `ack=1`, `ack_nmi=0`, `ack_idx` set to its index, and its pending flag is cleared.
- R7: If the winning request's level is not below `cur_lvl`, or if `int_en=0`, the wake gives `resume_next=1` with `ack=0`. The request stays pending. On every wake exactly one of `ack` and `resume_next` is high.
- R8: The winning maskable request is the pending, enabled request with the smallest 3-bit level in `irq_prio[3*i+2:3*i]`, where 0 is the most urgent. Ties go to the lowest index.
- R9: A high level on any of `rst_pin`, `rst_wdt`, `rst_lvd` or `rst_clkmon` drives `rst_out` high in the same cycle. At the next edge it ends the halt without a `wake` pulse and clears all pending flags. It has precedence over simultaneous interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request from the instruction decoder |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | N_IRQ | Maskable interrupt request levels |
| irq_en | input | N_IRQ | Per-request enable; 1 = unmasked |
| irq_prio | input | 3*N_IRQ | Packed 3-bit priority levels, 0 most urgent |
| int_en | input | 1 | Global maskable interrupt enable of the core |
| cur_lvl | input | 4 | Level being serviced; 8 = no handler active |
| rst_pin | input | 1 | External reset source |
| rst_wdt | input | 1 | Watchdog reset source |
| rst_lvd | input | 1 | Low-voltage reset source |
| rst_clkmon | input | 1 | Clock-monitor reset source |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| rst_out | output | 1 | Combined reset to the core |
| wake | output | 1 | One-cycle pulse when the halt ends by interrupt |
| ack | output | 1 | Waking request is taken |
| ack_nmi | output | 1 | The taken request is the non-maskable one |
| ack_idx | output | $clog2(N_IRQ) | Index of the taken maskable request |
| resume_next | output | 1 | Core resumes at the next instruction |

## Verification
A corrupted pending flag shows up as a wrong outcome on a later halt:

- A lost flag leaves `cpu_clk_en` low indefinitely.
- A stale flag wakes the core the cycle after entry, or acknowledges the wrong index.

Each trial therefore halts twice when the first wake resumes without an acknowledge. The second halt, with handling allowed, must acknowledge the same index. A wrong halt state appears within one cycle as `cpu_clk_en` or a `wake` pulse out of step with the request pattern. A wrong arbitration choice shows in `ack_idx` in the wake cycle itself.

// File: rtl/halt_wake_pkg.sv
// Package: shared types of the halt and wake controller.
package halt_wake_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } hw_state_e;
endpackage

// File: rtl/hw_pending.sv
// Module: hw_pending
// Holds one level-latched pending flag per maskable request plus one for the
// non-maskable request. A flag is set by its request, cleared by an acknowledge
// of that request (a request high on that edge sets it again), and cleared
// unconditionally by clr_all. Assumes clr_idx is valid when clr_irq is high.
module hw_pending #(
    parameter int N_IRQ = 8,
    localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             nmi,
    input  logic             clr_irq,
    input  logic [IW-1:0]    clr_idx,
    input  logic             clr_nmi,
    output logic [N_IRQ-1:0] pend,
    output logic             nmi_pend
);
    generate
        for (genvar g = 0; g < N_IRQ; g++) begin : g_flag
            logic hit;
            assign hit = clr_irq && (clr_idx == IW'(g));
            // Per-request pending flag: set by level, cleared by acknowledge or reset source.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_all) pend[g] <= 1'b0;
                else                   pend[g] <= (pend[g] && !hit) || irq_req[g];
            end
        end
    endgenerate

    // Non-maskable pending flag with the same set and clear rules.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) nmi_pend <= 1'b0;
        else                   nmi_pend <= (nmi_pend && !clr_nmi) || nmi;
    end
endmodule

// File: rtl/hw_arbiter.sv
// Module: hw_arbiter
// Combinational pick among eligible requests: smallest level wins, ties go to
// the lowest index. Assumes levels are packed PW bits per request, request 0
// in the least significant slot.
module hw_arbiter #(
    parameter int N_IRQ = 8,
    parameter int PW    = 3,
    localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0]    elig,
    input  logic [N_IRQ*PW-1:0] prio_flat,
    output logic                any,
    output logic [IW-1:0]       idx,
    output logic [PW-1:0]       lvl
);
    logic [PW-1:0] prio [N_IRQ];

    generate
        for (genvar g = 0; g < N_IRQ; g++) begin : g_unpack
            assign prio[g] = prio_flat[g*PW +: PW];
        end
    endgenerate

    // Linear scan: a later entry replaces the choice only with a strictly smaller level.
    always_comb begin
        any = 1'b0;
        idx = '0;
        lvl = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (elig[i] && (!any || prio[i] < lvl)) begin
                any = 1'b1;
                idx = IW'(i);
                lvl = prio[i];
            end
        end
    end
endmodule

// File: rtl/hw_fsm.sv
// Module: hw_fsm
// Run/halt state and the wake decision. The halt is left when wake_cond holds;
// on that edge it registers either an acknowledge (non-maskable first, then a
// maskable winner above the current level with interrupts enabled) or a
// resume-next indication. A reset source forces the run state with no pulses.
module hw_fsm
    import halt_wake_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int PW    = 3,
    localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_src,
    input  logic          halt_req,
    input  logic          nmi_pend,
    input  logic          arb_any,
    input  logic [IW-1:0] arb_idx,
    input  logic [PW-1:0] arb_lvl,
    input  logic          int_en,
    input  logic [PW:0]   cur_lvl,
    output logic          cpu_clk_en,
    output logic          wake,
    output logic          ack,
    output logic          ack_nmi,
    output logic [IW-1:0] ack_idx,
    output logic          resume_next,
    output logic          clr_irq,
    output logic [IW-1:0] clr_idx,
    output logic          clr_nmi
);
    hw_state_e state;
    logic      wake_cond;
    logic      take_nmi;
    logic      take_irq;
    logic      leave;

    // Decide wake and acceptance from the registered pending state.
    always_comb begin
        wake_cond = nmi_pend || arb_any;
        take_nmi  = nmi_pend;
        take_irq  = !nmi_pend && int_en && arb_any && ({1'b0, arb_lvl} < cur_lvl);
        leave     = (state == ST_HALT) && wake_cond && !rst_src;
        clr_nmi   = leave && take_nmi;
        clr_irq   = leave && take_irq;
        clr_idx   = arb_idx;
    end

    // State register and one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_RUN;
            wake        <= 1'b0;
            ack         <= 1'b0;
            ack_nmi     <= 1'b0;
            ack_idx     <= '0;
            resume_next <= 1'b0;
        end else begin
            wake        <= 1'b0;
            ack         <= 1'b0;
            ack_nmi     <= 1'b0;
            resume_next <= 1'b0;
            if (rst_src) begin
                state <= ST_RUN;
            end else if (state == ST_RUN) begin
                if (halt_req) state <= ST_HALT;
            end else if (wake_cond) begin
                state       <= ST_RUN;
                wake        <= 1'b1;
                ack         <= take_nmi || take_irq;
                ack_nmi     <= take_nmi;
                ack_idx     <= take_irq ? arb_idx : '0;
                resume_next <= !(take_nmi || take_irq);
            end
        end
    end

    assign cpu_clk_en = (state == ST_RUN);
endmodule

// File: rtl/halt_wake_ctrl.sv
// Module: halt_wake_ctrl (top)
// Halt entry and wake-up for a small core. Gates only the CPU clock enable;
// the peripheral clock enable stays high. Assumes all request and reset
// source inputs are synchronous to clk.
module halt_wake_ctrl #(
    parameter int N_IRQ = 8,
    parameter int PW    = 3,
    localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_req,
    input  logic                nmi,
    input  logic [N_IRQ-1:0]    irq_req,
    input  logic [N_IRQ-1:0]    irq_en,
    input  logic [N_IRQ*PW-1:0] irq_prio,
    input  logic                int_en,
    input  logic [PW:0]         cur_lvl,
    input  logic                rst_pin,
    input  logic                rst_wdt,
    input  logic                rst_lvd,
    input  logic                rst_clkmon,
    output logic                cpu_clk_en,
    output logic                periph_clk_en,
    output logic                rst_out,
    output logic                wake,
    output logic                ack,
    output logic                ack_nmi,
    output logic [IW-1:0]       ack_idx,
    output logic                resume_next
);
    logic [N_IRQ-1:0] pend;
    logic             nmi_pend;
    logic             arb_any;
    logic [IW-1:0]    arb_idx;
    logic [PW-1:0]    arb_lvl;
    logic             clr_irq;
    logic [IW-1:0]    clr_idx;
    logic             clr_nmi;

    assign rst_out       = rst_pin || rst_wdt || rst_lvd || rst_clkmon;
    assign periph_clk_en = 1'b1;

    hw_pending #(.N_IRQ(N_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr_all(rst_out),
        .irq_req(irq_req), .nmi(nmi),
        .clr_irq(clr_irq), .clr_idx(clr_idx), .clr_nmi(clr_nmi),
        .pend(pend), .nmi_pend(nmi_pend)
    );

    hw_arbiter #(.N_IRQ(N_IRQ), .PW(PW)) u_arb (
        .elig(pend & irq_en), .prio_flat(irq_prio),
        .any(arb_any), .idx(arb_idx), .lvl(arb_lvl)
    );

    hw_fsm #(.N_IRQ(N_IRQ), .PW(PW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rst_src(rst_out), .halt_req(halt_req),
        .nmi_pend(nmi_pend), .arb_any(arb_any), .arb_idx(arb_idx),
        .arb_lvl(arb_lvl), .int_en(int_en), .cur_lvl(cur_lvl),
        .cpu_clk_en(cpu_clk_en), .wake(wake), .ack(ack), .ack_nmi(ack_nmi),
        .ack_idx(ack_idx), .resume_next(resume_next),
        .clr_irq(clr_irq), .clr_idx(clr_idx), .clr_nmi(clr_nmi)
    );
endmodule

// File: rtl/halt_wake_ctrl_chk.sv
// Module: halt_wake_ctrl_chk
// Port-level temporal checks of the halt and wake controller, bound to the top.
module halt_wake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic int_en,
    input logic cpu_clk_en,
    input logic rst_out,
    input logic wake,
    input logic ack,
    input logic ack_nmi,
    input logic resume_next
);
    AST_HALT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && cpu_clk_en && !rst_out) |=> !cpu_clk_en); // R1
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake); // R3
    AST_WAKE_CLOCK_ON: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> cpu_clk_en); // R3
    AST_NMI_IS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> ack); // R5
    AST_DI_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_nmi) |-> $past(int_en)); // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ack != resume_next)); // R7
    AST_OUTCOME_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || resume_next) |-> wake); // R7
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> (cpu_clk_en && !wake)); // R9
endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .int_en(int_en),
    .cpu_clk_en(cpu_clk_en), .rst_out(rst_out), .wake(wake), .ack(ack),
    .ack_nmi(ack_nmi), .resume_next(resume_next)
);

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, nmi = 0, int_en = 0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic [PW:0] cur_lvl = 4'd8;
    logic rst_pin = 0, rst_wdt = 0, rst_lvd = 0, rst_clkmon = 0;
    logic cpu_clk_en, periph_clk_en, rst_out, wake, ack, ack_nmi, resume_next;
    logic [IW-1:0] ack_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    halt_wake_ctrl #(.N_IRQ(N), .PW(PW)) u_halt_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .nmi(nmi),
        .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
        .int_en(int_en), .cur_lvl(cur_lvl), .rst_pin(rst_pin),
        .rst_wdt(rst_wdt), .rst_lvd(rst_lvd), .rst_clkmon(rst_clkmon),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .rst_out(rst_out), .wake(wake), .ack(ack), .ack_nmi(ack_nmi),
        .ack_idx(ack_idx), .resume_next(resume_next)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic pulse_rst();
        rst_pin = 1'b1;
        nxt();
        rst_pin = 1'b0;
    endtask

    // Halt request for one cycle; on return the entry edge has passed.
    task automatic do_halt();
        halt_req = 1'b1;
        nxt();
        halt_req = 1'b0;
    endtask

    task automatic set_prio(input int i, input int l);
        irq_prio[i*PW +: PW] = PW'(l);
    endtask

    // Winner among eligible requests: smallest level, then lowest index.
    function automatic int winner(input logic [N-1:0] elig, input logic [N*PW-1:0] pr,
                                  output int lvl);
        int w = -1;
        lvl = 99;
        for (int i = 0; i < N; i++)
            if (elig[i] && int'(pr[i*PW +: PW]) < lvl) begin
                w = i;
                lvl = int'(pr[i*PW +: PW]);
            end
        return w;
    endfunction

    task automatic run_trial(input logic [N-1:0] en, input logic [N-1:0] reqv,
                             input logic nb, input logic ie, input int cur);
        int w, lvl;
        bit taken;
        pulse_rst();
        irq_en = en; int_en = ie; cur_lvl = 4'(cur);
        irq_req = reqv; nmi = nb;
        nxt();
        irq_req = '0; nmi = 1'b0;
        do_halt();
        check("R4 halt entry gates clock", int'(cpu_clk_en), 0);
        w = winner(reqv & en, irq_prio, lvl);
        if (!nb && w < 0) begin
            repeat (3) nxt();
            check("R3 masked requests keep halt", int'(cpu_clk_en), 0);
            return;
        end
        nxt();
        check("R3 wake pulse", int'(wake), 1);
        check("R3 clock restored", int'(cpu_clk_en), 1);
        if (nb) begin
            check("R5 nmi ack", int'(ack_nmi), 1);
            check("R5 nmi taken", int'(ack), 1);
            nxt();
            check("R3 wake one cycle", int'(wake), 0);
            return;
        end
        taken = ie && (lvl < cur);
        check("R7 ack vs resume", int'(ack), int'(taken));
        check("R7 resume_next", int'(resume_next), int'(!taken));
        if (taken) check("R8 ack index", int'(ack_idx), w);
        nxt();
        check("R3 wake one cycle", int'(wake), 0);
        if (!taken) begin
            int_en = 1'b1; cur_lvl = 4'd8;
            do_halt();
            nxt();
            check("R7 kept pending is acknowledged", int'(ack), 1);
            check("R7 kept pending index", int'(ack_idx), w);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) nxt();
        rst_n = 1'b1;
        nxt();
        check("R1 reset clock enable", int'(cpu_clk_en), 1);
        check("R1 periph enable", int'(periph_clk_en), 1);
        check("R3 reset no wake", int'(wake), 0);
        check("R9 reset rst_out", int'(rst_out), 0);

        // Halt with nothing pending, then a disabled request, then an enabled one.
        for (int i = 0; i < N; i++) set_prio(i, i % 8);
        irq_en = 8'b1111_1011; int_en = 1'b1; cur_lvl = 4'd8;
        do_halt();
        check("R1 clock gated", int'(cpu_clk_en), 0);
        check("R1 periph kept", int'(periph_clk_en), 1);
        irq_req = 8'b0000_0100; nxt(); irq_req = '0;
        repeat (3) nxt();
        check("R3 disabled request no wake", int'(cpu_clk_en), 0);
        irq_req = 8'b0100_0000; nxt(); irq_req = '0;
        nxt();
        check("R6 wake ack", int'(ack), 1);
        check("R6 ack index", int'(ack_idx), 6);
        check("R6 not nmi", int'(ack_nmi), 0);
        do_halt();
        repeat (2) nxt();
        check("R2 acked flag cleared", int'(cpu_clk_en), 0);
        pulse_rst();

        // Non-maskable wake with interrupts globally disabled and a busy level.
        int_en = 1'b0; cur_lvl = 4'd0;
        do_halt();
        nmi = 1'b1; nxt(); nmi = 1'b0;
        nxt();
        check("R5 nmi under disable", int'(ack_nmi), 1);

        // Reset source beats a simultaneous interrupt.
        int_en = 1'b1; cur_lvl = 4'd8;
        do_halt();
        rst_wdt = 1'b1; nmi = 1'b1; irq_req = 8'b0000_0010;
        #1 check("R9 rst_out same cycle", int'(rst_out), 1);
        nxt();
        rst_wdt = 1'b0; nmi = 1'b0; irq_req = '0;
        check("R9 halt ended by reset", int'(cpu_clk_en), 1);
        check("R9 no wake on reset", int'(wake), 0);
        do_halt();
        repeat (2) nxt();
        check("R9 pending cleared", int'(cpu_clk_en), 0);
        rst_lvd = 1'b1; nxt(); rst_lvd = 1'b0;
        check("R9 low-voltage reset ends halt", int'(cpu_clk_en), 1);

        // Tie on level: lowest index wins.
        set_prio(5, 1); set_prio(2, 1); set_prio(1, 3);
        run_trial(8'hFF, 8'b0010_0110, 1'b0, 1'b1, 8);
        set_prio(1, 1);

        for (int t = 0; t < 300; t++) begin
            logic [N-1:0] en = N'($urandom);
            logic [N-1:0] rq = N'($urandom) & N'($urandom);
            for (int i = 0; i < N; i++) set_prio(i, int'($urandom % 8));
            run_trial(en, rq, ($urandom % 8) == 0, 1'($urandom), int'($urandom % 9));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule